// File: doc/BRIEF.md
# Histogram Accumulation Engine

The engine counts how often each sample value occurs and keeps the counts in an external single-port synchronous memory, one counter per bin. The bin index is the upper `ADDR_W` bits of each sample. For every accepted sample the engine reads the bin, adds one and writes the result back. A start pulse first sets every bin to zero. After that the engine accumulates until the value written to some bin equals the target count on a static input. It then pulses `done` and goes idle.

The engine does not pipeline two updates through the single memory port. A sample that arrives while a write-back is in progress is dropped and counted in a saturating drop counter. The one exception is a sample for the bin being written: it is accepted, and its update uses the value just written instead of a fresh read. Host readout of the memory is left to other logic once `busy` falls.

Top module: `hist_accum_engine`

## Requirements
- R1: After reset, `busy`, `clearing`, `done`, `mem_en` and `drop_cnt` are all zero.
- R2: A `start` pulse while idle raises `busy` and `clearing` on the next cycle. For the following 2^ADDR_W cycles the engine writes zero (`mem_en`=1, `mem_we`=1) to addresses 0, 1, 2 … 2^ADDR_W−1 in ascending order, one per cycle. `clearing` then falls and accumulation begins.
- R3: `start` is ignored while `busy` is high; a pulse during the clear neither restarts nor lengthens it.
- R4: During the clear, `smp_valid` causes no memory read and does not change `drop_cnt`.
- R5: In an accumulation cycle with no update pending, `smp_valid` issues a read in that same cycle (`mem_en`=1, `mem_we`=0). The address is `smp_data[SAMPLE_W-1 -: ADDR_W]`; the lower sample bits have no effect.
- R6: In the cycle after a read, the engine writes the read data plus one to the same address.
- R7: A sample whose bin equals the bin being written in a write cycle is accepted without a read. The following cycle writes the value just written plus one to that bin.
- R8: A sample for a different bin during a write cycle is dropped. `drop_cnt` rises by one on the next cycle and saturates at 2^DROP_W−1. A `start` accepted while idle resets `drop_cnt` to zero.
- R9: When the value written equals `target`, the next cycle shows `done`=1 and `busy`=0. `done` lasts exactly one cycle, and the engine makes no further memory access until the next start. A sample in the terminating write cycle is neither accepted nor counted as dropped.
- R10: The memory read latency is one cycle: `mem_rdata` is consumed in the cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: clear all bins, then accumulate |
| target | input | CNT_W | Static count at which accumulation ends |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_data | input | SAMPLE_W | Sample value; upper ADDR_W bits select the bin |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | CNT_W | Memory write data |
| mem_rdata | input | CNT_W | Memory read data, one cycle after a read |
| busy | output | 1 | Clearing or accumulating |
| clearing | output | 1 | Zero-fill in progress |
| done | output | 1 | One-cycle pulse after the terminating write |
| drop_cnt | output | DROP_W | Saturating count of dropped samples |

## Verification
Isolated samples with idle gaps exercise the plain read-increment-write path and the upper-bit address mapping. Back-to-back samples to the same bin show that forwarding is used instead of a stale read. Back-to-back samples to different bins show the drop path and its saturation. Samples and start pulses during the zero-fill show that the clear cannot be disturbed, and a bench memory preloaded with nonzero junk shows that every bin is really zeroed. The run is ended once by a plain update and once by a drop-pattern pair, which checks that a sample in the terminating cycle is not counted.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2,
        ST_WRITE = 2'd3
    } hist_state_e;
endpackage

// File: rtl/hist_clear_walker.sv
module hist_clear_walker #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (restart)   addr_d = '0;
        else if (step) addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
    assign last = (addr_q == {ADDR_W{1'b1}});

    // R2
    clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/hist_sat_counter.sv
module hist_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (inc && cnt_q != MAX_VAL) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R8
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != MAX_VAL) |=> (count == $past(count) + 1'b1));
    // R8
    drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == MAX_VAL) |=> (count == MAX_VAL));
endmodule

// File: rtl/hist_bin_update.sv
module hist_bin_update #(
    parameter int CNT_W = 16
) (
    input  logic             use_fwd,
    input  logic [CNT_W-1:0] fwd_val,
    input  logic [CNT_W-1:0] rd_val,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] next_val,
    output logic             hit
);
    logic [CNT_W-1:0] base;

    always_comb begin
        base     = use_fwd ? fwd_val : rd_val;
        next_val = base + 1'b1;
        hit      = (next_val == target);
    end
endmodule

// File: rtl/hist_accum_engine.sv
module hist_accum_engine
    import hist_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 16,
    parameter int DROP_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    target,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [CNT_W-1:0]    mem_wdata,
    input  logic [CNT_W-1:0]    mem_rdata,
    output logic                busy,
    output logic                clearing,
    output logic                done,
    output logic [DROP_W-1:0]   drop_cnt
);
    localparam int LOW_W = SAMPLE_W - ADDR_W;

    typedef struct packed {
        hist_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic              fwd;
        logic [CNT_W-1:0]  last;
        logic              done;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [ADDR_W-1:0] smp_addr;
    logic [ADDR_W-1:0] clr_addr;
    logic              clr_last, clr_restart, clr_step;
    logic              drop_inc;
    logic [CNT_W-1:0]  bin_next;
    logic              bin_hit;

    assign smp_addr = smp_data[SAMPLE_W-1 -: ADDR_W];

    generate
        if (LOW_W > 0) begin : g_low
            logic smp_low_unused;
            assign smp_low_unused = ^smp_data[LOW_W-1:0];
        end
    endgenerate

    hist_clear_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .restart(clr_restart), .step(clr_step),
        .addr(clr_addr), .last(clr_last)
    );

    hist_sat_counter #(.CNT_W(DROP_W)) u_drops (
        .clk(clk), .rst_n(rst_n), .clr(clr_restart), .inc(drop_inc),
        .count(drop_cnt)
    );

    hist_bin_update #(.CNT_W(CNT_W)) u_bin (
        .use_fwd(cur_q.fwd), .fwd_val(cur_q.last), .rd_val(mem_rdata),
        .target(target), .next_val(bin_next), .hit(bin_hit)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.done  = 1'b0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        drop_inc    = 1'b0;
        clr_restart = 1'b0;
        clr_step    = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.state = ST_CLEAR;
                    clr_restart = 1'b1;
                end
            end
            ST_CLEAR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = clr_addr;
                clr_step = 1'b1;
                if (clr_last) nxt_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (smp_valid) begin
                    mem_en      = 1'b1;
                    mem_addr    = smp_addr;
                    nxt_d.addr  = smp_addr;
                    nxt_d.fwd   = 1'b0;
                    nxt_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_en     = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = cur_q.addr;
                mem_wdata  = bin_next;
                nxt_d.last = bin_next;
                if (bin_hit) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end else if (smp_valid && smp_addr == cur_q.addr) begin
                    nxt_d.fwd   = 1'b1;
                end else begin
                    nxt_d.state = ST_RUN;
                    drop_inc    = smp_valid;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.addr  <= '0;
            cur_q.fwd   <= 1'b0;
            cur_q.last  <= '0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy     = (cur_q.state != ST_IDLE);
    assign clearing = (cur_q.state == ST_CLEAR);
    assign done     = cur_q.done;

    // R4
    clear_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (mem_en && mem_we && mem_wdata == '0));
    // R6
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we && mem_addr == $past(mem_addr)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_en));
    // R3
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && mem_addr != {ADDR_W{1'b1}}) |=> clearing);
endmodule

// File: tb/tb_hist_accum_engine.sv
module tb_hist_accum_engine;
    localparam int SW = 12;
    localparam int AW = 8;
    localparam int CW = 16;
    localparam int DW = 3;
    localparam int N  = 1 << AW;
    localparam int DMAX = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] target = '0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] mem_wdata;
    logic [CW-1:0] mem_rdata = '0;
    logic          busy, clearing, done;
    logic [DW-1:0] drop_cnt;

    hist_accum_engine #(.SAMPLE_W(SW), .ADDR_W(AW), .CNT_W(CW), .DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .clearing(clearing), .done(done), .drop_cnt(drop_cnt)
    );

    always #4 clk = ~clk;

    logic [CW-1:0] mem [N];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    typedef struct { int a; int d; string req; } wr_t;
    wr_t exp_q[$];
    int  model [N];
    int  tests = 0;
    int  fails = 0;
    int  drops_exp = 0;
    int  clr_idx = 0;
    bit  expect_done = 0;
    bit  done_after = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_after) begin
                check(done == 1'b0, "R9", "done width", int'(done), 0);
                done_after = 0;
            end
            if (expect_done) begin
                check(done == 1'b1, "R9", "done pulse", int'(done), 1);
                check(busy == 1'b0, "R9", "busy after end", int'(busy), 0);
                expect_done = 0;
                done_after  = 1;
            end
            if (clearing) begin
                check(mem_en && mem_we && int'(mem_addr) == clr_idx && mem_wdata == 0,
                      "R2", "clear write address", int'(mem_addr), clr_idx);
                clr_idx++;
            end else if (mem_en && mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", int'(mem_addr), -1);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(int'(mem_addr) == e.a, e.req, "write address", int'(mem_addr), e.a);
                    check(int'(mem_wdata) == e.d, e.req, "write data", int'(mem_wdata), e.d);
                    if (e.d == int'(target)) expect_done = 1;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(bit v, int a);
        smp_valid = v;
        smp_data  = SW'((a << (SW - AW)) | ((a * 7 + 3) & ((1 << (SW - AW)) - 1)));
    endtask

    task automatic push(int a, string req, output bit hit);
        wr_t e;
        model[a]++;
        e.a = a; e.d = model[a]; e.req = req;
        exp_q.push_back(e);
        hit = (model[a] == int'(target));
    endtask

    task automatic read_check(int a);
        @(negedge clk);
        check(mem_en && !mem_we && int'(mem_addr) == a, "R5", "read address", int'(mem_addr), a);
    endtask

    task automatic one(int a);
        bit h;
        tick(); put(1, a);
        read_check(a);
        push(a, "R6", h);
        tick(); put(0, 0);
    endtask

    task automatic pair_same(int a);
        bit h;
        tick(); put(1, a);
        read_check(a);
        push(a, "R6", h);
        tick(); put(1, a);
        push(a, "R7", h);
        tick(); put(0, 0);
    endtask

    task automatic pair_diff(int a, int b);
        bit h;
        tick(); put(1, a);
        read_check(a);
        push(a, "R6", h);
        tick(); put(1, b);
        if (!h && drops_exp < DMAX) drops_exp++;
        tick(); put(0, 0);
        @(negedge clk);
        check(int'(drop_cnt) == drops_exp, h ? "R9" : "R8", "drop count",
              int'(drop_cnt), drops_exp);
    endtask

    task automatic start_run(int tgt);
        target  = CW'(tgt);
        clr_idx = 0;
        tick(); start = 1'b1;
        tick(); start = 1'b0;
        @(negedge clk);
        check(busy && clearing, "R2", "busy and clearing after start",
              int'({busy, clearing}), 3);
        for (int i = 0; i < N; i++) model[i] = 0;
        drops_exp = 0;
        repeat (20) tick();
        start = 1'b1; put(1, 17);
        tick(); start = 1'b0;
        tick(); put(0, 0);
        while (clearing) @(negedge clk);
        check(clr_idx == N, "R3", "clear length", clr_idx, N);
        check(drop_cnt == 0, "R4", "drops after clear", int'(drop_cnt), 0);
        begin
            int nz;
            nz = 0;
            for (int i = 0; i < N; i++) if (mem[i] != 0) nz++;
            check(nz == 0, "R2", "nonzero bins after clear", nz, 0);
        end
    endtask

    task automatic quiet_after_end();
        tick(); put(1, 50); start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!mem_en && !busy, "R9", "access after end", int'(mem_en), 0);
            tick();
        end
        put(0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9", "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mem[i] = CW'(i * 3 + 1);
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !clearing && !done && !mem_en && drop_cnt == 0, "R1",
              "reset outputs", int'({busy, clearing, done, mem_en}), 0);

        // run 1: target 4
        start_run(4);
        one(5);
        pair_same(5);
        pair_diff(7, 9);
        one(9);
        one(10); one(10); one(10);
        pair_diff(10, 30);
        check(int'(mem[10]) == 4, "R10", "bin 10 in memory", int'(mem[10]), 4);
        check(int'(mem[5]) == 3, "R7", "bin 5 in memory", int'(mem[5]), 3);
        quiet_after_end();

        // run 2: target 3, drop saturation
        start_run(3);
        for (int i = 0; i < 9; i++) pair_diff(i, i + 100);
        check(int'(drop_cnt) == DMAX, "R8", "saturated drops", int'(drop_cnt), DMAX);
        one(40); one(40); one(40);
        tick();
        check(exp_q.size() == 0, "R6", "pending writes", exp_q.size(), 0);
        quiet_after_end();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule